// File: doc/BRIEF.md
# LIN Frame Header and Response Controller

This block runs a LIN frame at the level of bytes. It sits on top of a bit engine, which turns the serial line into bytes and back. In slave mode it watches the line for a break, which is a long run of dominant bits. It then expects a sync byte and captures the protected identifier. It checks the two parity bits of that identifier and announces the new identifier to software. In master mode a single command sends the whole header instead: a break request, the sync byte and the identifier with its parity bits. This also ends in the identifier-available event.

After the header, software starts either a response receive or a response transmit of 1 to 8 data bytes. The controller closes the response with an inverted end-around-carry checksum, in classic or enhanced form. Identifiers 62 and 63 carry user-defined frames. For these the bytes are moved raw, with no checksum byte and no checksum check. A wake-up command sends one byte whose low run suits the selected protocol generation. Software sees four sticky interrupt flags, cleared by writing one. It also sees per-identifier flags for 60 to 63 and a set of error cause bits.

Top module: `lin_frame_ctrl`

## Requirements
- R1: In slave mode (CTRL bit0 = 0), a low line held for at least BREAK_BITS bit ticks and then sampled high starts a header. The next byte must be 0x55, and the byte after it is taken as the protected identifier. Bytes that arrive with no break before them are ignored, and so is a low run that is too short.
- R2: A sync byte other than 0x55 sets the error flag (STATUS bit3) and error cause STATUS bit12.
- R3: The protected identifier holds the 6-bit identifier in bits 5:0, P0 in bit 6 and P1 in bit 7, where P0 = ID0^ID1^ID2^ID4 and P1 = ~(ID1^ID3^ID4^ID5). A correct identifier sets the identifier flag (STATUS bit0) and can be read at address 3. A parity mismatch sets the error flag and cause bit8 and leaves the identifier flag clear.
- R4: STATUS bits 4, 5, 6 and 7 are high while the captured identifier is 60, 61, 62 or 63, in that order.
- R5: In master mode (CTRL bit0 = 1), writing 1 to CMD bit0 sends three items in order: a break request (tx_brk high), the byte 0x55, and the protected form of the identifier written to address 3. Each item is held until tx_ready is high. The identifier flag is then set.
- R6: CMD bit1 receives LEN data bytes into the data buffer (addresses 8 to 15), followed by a checksum byte. The checksum is the end-around-carry sum of the data, inverted. With CTRL bit1 = 1 the protected identifier is also included in the sum. A match sets the receive flag (STATUS bit1); a mismatch sets the error flag and cause bit9.
- R7: CMD bit2 sends LEN bytes from the data buffer and then the checksum formed as in R6. The transmit flag (STATUS bit2) is then set.
- R8: When the captured identifier is 62 or 63, receive and transmit move exactly LEN bytes, with no checksum byte and no check, and then set their flag.
- R9: CMD bit3 sends one wake-up byte: 0xF0 when CTRL bit2 = 0, and 0x80 when CTRL bit2 = 1.
- R10: Each of STATUS bits 3:0 stays set until software writes 1 to that bit at address 4. Writing 1 to bit3 also clears the cause bits 12:8. The four flags drive irq_idok, irq_rxok, irq_txok and irq_err.
- R11: A byte received with rx_ferr high during a header or a response sets the error flag and cause bit10. A pulse on bit_err while sending sets the error flag and cause bit11 and stops the transmission.
- R12: LEN (address 2) reads back clamped to the range 1 to MAX_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bit_tick | input | 1 | one pulse per bit time from the bit engine |
| line_rx | input | 1 | sampled line level (0 = dominant) |
| rx_valid | input | 1 | received byte strobe |
| rx_data | input | 8 | received byte |
| rx_ferr | input | 1 | framing error of the strobed byte |
| tx_valid | output | 1 | transmit item pending |
| tx_brk | output | 1 | pending item is a break request |
| tx_data | output | 8 | byte to send |
| tx_ready | input | 1 | bit engine accepts the item |
| bit_err | input | 1 | readback mismatch from the bit engine |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 4 | write address |
| wr_data | input | 8 | write data |
| rd_addr | input | 4 | read address |
| rd_data | output | 16 | read data |
| irq_idok | output | 1 | identifier available |
| irq_rxok | output | 1 | response received |
| irq_txok | output | 1 | response transmitted |
| irq_err | output | 1 | error |

## Verification
The bench feeds the header receiver all 64 identifiers, each once with correct parity and once with P1 flipped. This separates the parity equations, the readback of the identifier and the four special-identifier flags for every value. It also tries a break one tick too short and a wrong sync byte, which separates real header starts from stray bytes. Responses are received and sent for every length from 1 to 8, with both checksum forms. A corrupted checksum byte separates a true match from one that would be accepted anyway. Raw frames, master headers with a stalled bit engine, the two wake-up bytes, framing and readback errors, and selective flag clearing cover the remaining paths.

// File: rtl/lin_pkg.sv
package lin_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SYNC, ST_PID, ST_TBRK, ST_TSYNC, ST_TPID,
    ST_RRX, ST_RTX, ST_TCK, ST_WAKE
  } lin_st_e;

  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_CMD  = 4'd1;
  localparam logic [3:0] A_LEN  = 4'd2;
  localparam logic [3:0] A_ID   = 4'd3;
  localparam logic [3:0] A_STAT = 4'd4;

  localparam int F_IDOK = 0;
  localparam int F_RXOK = 1;
  localparam int F_TXOK = 2;
  localparam int F_ERR  = 3;

  localparam int E_PAR = 0;
  localparam int E_CKS = 1;
  localparam int E_FRM = 2;
  localparam int E_BIT = 3;
  localparam int E_SYN = 4;

  localparam logic [7:0] SYNC_BYTE = 8'h55;

  function automatic logic [7:0] lin_pid(input logic [5:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

  function automatic logic [7:0] lin_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction

endpackage

// File: rtl/lin_brk_det.sv
module lin_brk_det #(
  parameter int BREAK_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  output logic brk
);
  localparam int CW = $clog2(BREAK_BITS + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          brk_d;

  always_comb begin
    cnt_d = cnt_q;
    brk_d = 1'b0;
    if (tick) begin
      if (!line) begin
        if (cnt_q != CW'(BREAK_BITS)) cnt_d = cnt_q + 1'b1;
      end else begin
        brk_d = (cnt_q == CW'(BREAK_BITS));
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      brk   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      brk   <= brk_d;
    end
  end

  a_r1_brk_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> cnt_q == '0);
  a_r1_run_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(BREAK_BITS));

endmodule

// File: rtl/lin_cksum.sv
module lin_cksum (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic [7:0] seed,
  input  logic       add,
  input  logic [7:0] din,
  output logic [7:0] sum
);
  import lin_pkg::*;

  logic [7:0] sum_d;

  always_comb begin
    sum_d = sum;
    if (init)     sum_d = seed;
    else if (add) sum_d = lin_add(sum, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum <= 8'h00;
    else        sum <= sum_d;
  end

endmodule

// File: rtl/lin_frame_ctrl.sv
module lin_frame_ctrl #(
  parameter int BREAK_BITS = 11,
  parameter int MAX_LEN    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_tick,
  input  logic        line_rx,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_ferr,
  output logic        tx_valid,
  output logic        tx_brk,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  input  logic        bit_err,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [3:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic        irq_idok,
  output logic        irq_rxok,
  output logic        irq_txok,
  output logic        irq_err
);
  import lin_pkg::*;

  localparam int IW = $clog2(MAX_LEN + 1);
  localparam int AW = $clog2(MAX_LEN);

  logic [1:0] rs_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  lin_st_e       st_q, st_d;
  logic [IW-1:0] idx_q, idx_d, len_q, len_d;
  logic [7:0]    pid_q, pid_d;
  logic [5:0]    hid_q, hid_d;
  logic [2:0]    ctrl_q, ctrl_d;
  logic [3:0]    flg_q, flg_d, set_f;
  logic [4:0]    err_q, err_d, errs;
  logic          raw_q, raw_d;
  logic [7:0]    buf_q [MAX_LEN];
  logic [7:0]    buf_d [MAX_LEN];
  logic          brk, ck_init, ck_add, ext, tx_act;
  logic [7:0]    ck_seed, ck_byte, ck_sum;
  logic [3:0]    idf, wv;

  lin_brk_det #(.BREAK_BITS(BREAK_BITS)) u_brk (
    .clk(clk), .rst_n(rst_s), .tick(bit_tick), .line(line_rx), .brk(brk));

  lin_cksum u_ck (
    .clk(clk), .rst_n(rst_s), .init(ck_init), .seed(ck_seed),
    .add(ck_add), .din(ck_byte), .sum(ck_sum));

  assign ext = (pid_q[5:0] >= 6'd62);
  assign wv  = wr_data[3:0];
  generate
    for (genvar g = 0; g < 4; g++) begin : g_idf
      assign idf[g] = (pid_q[5:0] == 6'(60 + g));
    end
  endgenerate

  always_comb begin
    st_d = st_q; idx_d = idx_q; len_d = len_q; pid_d = pid_q; hid_d = hid_q;
    ctrl_d = ctrl_q; raw_d = raw_q; buf_d = buf_q;
    set_f = '0; errs = '0;
    ck_init = 1'b0; ck_seed = 8'h00; ck_add = 1'b0; ck_byte = 8'h00;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL: ctrl_d = wr_data[2:0];
        A_LEN:  len_d  = (wv == 4'd0) ? IW'(1) :
                         (32'(wv) > MAX_LEN) ? IW'(MAX_LEN) : IW'(wv);
        A_ID:   hid_d  = wr_data[5:0];
        default: if (wr_addr[3]) buf_d[wr_addr[AW-1:0]] = wr_data;
      endcase
    end
    case (st_q)
      ST_IDLE: if (wr_en && wr_addr == A_CMD) begin
        if (wr_data[0] && ctrl_q[0]) st_d = ST_TBRK;
        else if (wr_data[1] || wr_data[2]) begin
          st_d    = wr_data[1] ? ST_RRX : ST_RTX;
          idx_d   = '0;
          raw_d   = ext;
          ck_init = 1'b1;
          ck_seed = (ctrl_q[1] && !ext) ? pid_q : 8'h00;
        end else if (wr_data[3]) st_d = ST_WAKE;
      end
      ST_SYNC: if (rx_valid) begin
        st_d = ST_IDLE;
        if (rx_ferr)                 errs[E_FRM] = 1'b1;
        else if (rx_data == SYNC_BYTE) st_d = ST_PID;
        else                         errs[E_SYN] = 1'b1;
      end
      ST_PID: if (rx_valid) begin
        st_d = ST_IDLE;
        if (rx_ferr) errs[E_FRM] = 1'b1;
        else if (lin_pid(rx_data[5:0]) == rx_data) begin
          pid_d = rx_data;
          set_f[F_IDOK] = 1'b1;
        end else errs[E_PAR] = 1'b1;
      end
      ST_TBRK:  if (tx_ready) st_d = ST_TSYNC;
      ST_TSYNC: if (tx_ready) st_d = ST_TPID;
      ST_TPID:  if (tx_ready) begin
        pid_d = lin_pid(hid_q);
        set_f[F_IDOK] = 1'b1;
        st_d = ST_IDLE;
      end
      ST_RRX: if (rx_valid) begin
        if (rx_ferr) begin
          errs[E_FRM] = 1'b1;
          st_d = ST_IDLE;
        end else if (idx_q < len_q) begin
          buf_d[idx_q[AW-1:0]] = rx_data;
          ck_add  = 1'b1;
          ck_byte = rx_data;
          idx_d   = idx_q + 1'b1;
          if (raw_q && (idx_q + 1'b1 == len_q)) begin
            set_f[F_RXOK] = 1'b1;
            st_d = ST_IDLE;
          end
        end else begin
          if (rx_data == ~ck_sum) set_f[F_RXOK] = 1'b1;
          else                    errs[E_CKS]   = 1'b1;
          st_d = ST_IDLE;
        end
      end
      ST_RTX: if (tx_ready) begin
        ck_add  = 1'b1;
        ck_byte = buf_q[idx_q[AW-1:0]];
        idx_d   = idx_q + 1'b1;
        if (idx_q + 1'b1 == len_q) begin
          if (raw_q) begin
            set_f[F_TXOK] = 1'b1;
            st_d = ST_IDLE;
          end else st_d = ST_TCK;
        end
      end
      ST_TCK: if (tx_ready) begin
        set_f[F_TXOK] = 1'b1;
        st_d = ST_IDLE;
      end
      ST_WAKE: if (tx_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (tx_act && bit_err) begin
      errs[E_BIT] = 1'b1;
      st_d = ST_IDLE;
    end
    if (brk && !ctrl_q[0]) st_d = ST_SYNC;
    flg_d = flg_q;
    err_d = err_q;
    if (wr_en && wr_addr == A_STAT) begin
      flg_d = flg_q & ~wr_data[3:0];
      if (wr_data[F_ERR]) err_d = '0;
    end
    if (errs != '0) set_f[F_ERR] = 1'b1;
    flg_d = flg_d | set_f;
    err_d = err_d | errs;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q <= ST_IDLE; idx_q <= '0; len_q <= IW'(1); pid_q <= 8'h00;
      hid_q <= '0; ctrl_q <= '0; raw_q <= 1'b0; flg_q <= '0; err_q <= '0;
      for (int i = 0; i < MAX_LEN; i++) buf_q[i] <= 8'h00;
    end else begin
      st_q <= st_d; idx_q <= idx_d; len_q <= len_d; pid_q <= pid_d;
      hid_q <= hid_d; ctrl_q <= ctrl_d; raw_q <= raw_d; flg_q <= flg_d;
      err_q <= err_d; buf_q <= buf_d;
    end
  end

  always_comb begin
    tx_act  = 1'b1;
    tx_brk  = 1'b0;
    tx_data = 8'h00;
    case (st_q)
      ST_TBRK:  tx_brk  = 1'b1;
      ST_TSYNC: tx_data = SYNC_BYTE;
      ST_TPID:  tx_data = lin_pid(hid_q);
      ST_RTX:   tx_data = buf_q[idx_q[AW-1:0]];
      ST_TCK:   tx_data = ~ck_sum;
      ST_WAKE:  tx_data = ctrl_q[2] ? 8'h80 : 8'hF0;
      default:  tx_act  = 1'b0;
    endcase
  end
  assign tx_valid = tx_act;

  always_comb begin
    rd_data = 16'h0000;
    case (rd_addr)
      A_CTRL: rd_data = 16'(ctrl_q);
      A_LEN:  rd_data = 16'(len_q);
      A_ID:   rd_data = 16'(pid_q);
      A_STAT: rd_data = {3'b000, err_q, idf, flg_q};
      default: if (rd_addr[3]) rd_data = 16'(buf_q[rd_addr[AW-1:0]]);
    endcase
  end

  assign irq_idok = flg_q[F_IDOK];
  assign irq_rxok = flg_q[F_RXOK];
  assign irq_txok = flg_q[F_TXOK];
  assign irq_err  = flg_q[F_ERR];

  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_s)
    tx_valid && !tx_ready && !bit_err && !brk |=>
      tx_valid && $stable(tx_data) && $stable(tx_brk));
  a_r4_idflags_onehot: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(idf));
  a_r11_err_has_cause: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(irq_err) |-> err_q != '0);
  a_r6_idx_bound: assert property (@(posedge clk) disable iff (!rst_s)
    32'(idx_q) <= MAX_LEN);
  a_r10_rxok_sticky: assert property (@(posedge clk) disable iff (!rst_s)
    irq_rxok && !(wr_en && wr_addr == A_STAT && wr_data[F_RXOK]) |=> irq_rxok);
  a_r8_raw_no_cksum: assert property (@(posedge clk) disable iff (!rst_s)
    st_q == ST_TCK |-> !raw_q);

endmodule

// File: tb/lin_frame_ctrl_tb.sv
module lin_frame_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b1, line_rx = 1'b1;
  logic rx_valid = 1'b0, rx_ferr = 1'b0, tx_ready = 1'b1, bit_err = 1'b0;
  logic [7:0] rx_data = 8'h00, wr_data = 8'h00;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = 4'h0, rd_addr = 4'h0;
  logic tx_valid, tx_brk;
  logic [7:0] tx_data;
  logic [15:0] rd_data;
  logic irq_idok, irq_rxok, irq_txok, irq_err;
  int total = 0, bad = 0, tx_n = 0;
  logic done = 1'b0;
  logic [8:0] tx_log [256];

  always #4 clk = ~clk;

  lin_frame_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .line_rx(line_rx),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ferr(rx_ferr),
    .tx_valid(tx_valid), .tx_brk(tx_brk), .tx_data(tx_data), .tx_ready(tx_ready),
    .bit_err(bit_err), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_idok(irq_idok),
    .irq_rxok(irq_rxok), .irq_txok(irq_txok), .irq_err(irq_err));

  always @(posedge clk) if (tx_valid && tx_ready) begin
    tx_log[tx_n[7:0]] <= {tx_brk, tx_data};
    tx_n <= tx_n + 1;
  end

  function automatic logic [7:0] pid_of(input logic [5:0] id);
    return {~(id[1]^id[3]^id[4]^id[5]), id[0]^id[1]^id[2]^id[4], id};
  endfunction
  function automatic logic [7:0] csum_step(input logic [7:0] a, input logic [7:0] b);
    int s;
    s = int'(a) + int'(b);
    if (s > 255) s = s - 255;
    return 8'(s);
  endfunction
  function automatic logic [7:0] dbyte(input int len, input int k);
    return 8'((len * 37 + k * 11 + 3) & 255);
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk); rd_addr = a; #1 v = rd_data;
  endtask
  task automatic brk(input int n);
    @(negedge clk); line_rx = 1'b0;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); line_rx = 1'b1;
    repeat (2) @(negedge clk);
  endtask
  task automatic rxb(input logic [7:0] b, input logic fe);
    @(negedge clk); rx_valid = 1'b1; rx_data = b; rx_ferr = fe;
    @(negedge clk); rx_valid = 1'b0; rx_ferr = 1'b0;
    repeat (2) @(negedge clk);
  endtask
  task automatic hdr(input logic [7:0] p);
    wr(4'd4, 8'h0F);
    brk(11); rxb(8'h55, 1'b0); rxb(p, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0] p, s;
    int st, ln;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 reset flags", {irq_idok, irq_rxok, irq_txok, irq_err, tx_valid}, 0);
    rd(4'd2, v); chk("R12 reset len", v, 1);

    // R1 R3 R4 exhaustive identifier sweep
    for (int id = 0; id < 64; id++) begin
      p = pid_of(6'(id));
      hdr(p);
      chk("R3 good parity idok", {irq_idok, irq_err}, 2'b10);
      rd(4'd3, v); chk("R3 pid readback", v, 16'(p));
      rd(4'd4, v);
      chk("R4 id flags", v[7:4], {id == 63, id == 62, id == 61, id == 60});
      hdr(p ^ 8'h80);
      chk("R3 bad parity", {irq_idok, irq_err, v[8] & 1'b0}, 3'b010);
      rd(4'd4, v); chk("R3 parity cause", v[12:8], 5'b00001);
    end

    // R1 short break ignored
    wr(4'd4, 8'h0F);
    brk(10); rxb(8'h55, 1'b0); rxb(pid_of(6'd5), 1'b0);
    chk("R1 short break ignored", {irq_idok, irq_err}, 0);
    rxb(8'h55, 1'b0);
    chk("R1 stray byte ignored", {irq_idok, irq_err}, 0);

    // R2 bad sync
    wr(4'd4, 8'h0F); brk(11); rxb(8'h54, 1'b0);
    rd(4'd4, v); chk("R2 sync error", {v[12:8], v[3:0]}, {5'b10000, 4'b1000});

    // R11 framing during header
    wr(4'd4, 8'h0F); brk(11); rxb(8'h55, 1'b1);
    rd(4'd4, v); chk("R11 framing", {v[12:8], v[3]}, {5'b00100, 1'b1});

    // R6 response receive, both checksum forms, all lengths
    p = pid_of(6'h10);
    for (int enh = 0; enh < 2; enh++) begin
      wr(4'd0, 8'(enh << 1));
      for (int len = 1; len <= 8; len++) begin
        for (int bad_ck = 0; bad_ck < 2; bad_ck++) begin
          hdr(p);
          wr(4'd2, 8'(len));
          wr(4'd1, 8'h02);
          s = (enh == 1) ? p : 8'h00;
          for (int k = 0; k < len; k++) begin
            rxb(dbyte(len, k), 1'b0);
            s = csum_step(s, dbyte(len, k));
          end
          rxb(~s ^ 8'(bad_ck), 1'b0);
          if (bad_ck == 0) begin
            chk("R6 rx checksum ok", {irq_rxok, irq_err}, 2'b10);
            rd(4'(8 + len - 1), v); chk("R6 rx buffer", v, 16'(dbyte(len, len - 1)));
          end else begin
            rd(4'd4, v); chk("R6 rx checksum bad", {irq_rxok, irq_err, v[12:8]}, {2'b01, 5'b00010});
          end
        end
      end
    end

    // R7 response transmit
    wr(4'd0, 8'h02);
    for (int len = 1; len <= 8; len++) begin
      hdr(p);
      wr(4'd2, 8'(len));
      for (int k = 0; k < len; k++) wr(4'(8 + k), dbyte(len + 9, k));
      st = tx_n;
      wr(4'd1, 8'h04);
      repeat (len + 4) @(negedge clk);
      chk("R7 tx count", tx_n - st, len + 1);
      s = p;
      for (int k = 0; k < len; k++) begin
        chk("R7 tx byte", tx_log[8'(st + k)], {1'b0, dbyte(len + 9, k)});
        s = csum_step(s, dbyte(len + 9, k));
      end
      chk("R7 tx checksum", tx_log[8'(st + len)], {1'b0, ~s});
      chk("R7 txok", irq_txok, 1);
    end

    // R8 raw frames for 62 and 63
    for (int id = 62; id < 64; id++) begin
      hdr(pid_of(6'(id)));
      ln = id - 59;
      wr(4'd2, 8'(ln));
      wr(4'd1, 8'h02);
      for (int k = 0; k < ln; k++) rxb(dbyte(id, k), 1'b0);
      chk("R8 raw rx done", {irq_rxok, irq_err}, 2'b10);
      rd(4'(8 + ln - 1), v); chk("R8 raw rx last", v, 16'(dbyte(id, ln - 1)));
      st = tx_n;
      wr(4'd1, 8'h04);
      repeat (ln + 4) @(negedge clk);
      chk("R8 raw tx count", tx_n - st, ln);
      chk("R8 raw txok", irq_txok, 1);
    end

    // R9 wake bytes
    wr(4'd0, 8'h00); st = tx_n; wr(4'd1, 8'h08); repeat (3) @(negedge clk);
    chk("R9 wake 2.x", {23'd0, tx_log[8'(st)]}, 32'h0F0);
    wr(4'd0, 8'h04); st = tx_n; wr(4'd1, 8'h08); repeat (3) @(negedge clk);
    chk("R9 wake 1.3", {23'd0, tx_log[8'(st)]}, 32'h080);

    // R5 master header with stalled bit engine
    wr(4'd4, 8'h0F);
    wr(4'd0, 8'h01); wr(4'd3, 8'h2A);
    tx_ready = 1'b0; st = tx_n;
    wr(4'd1, 8'h01);
    repeat (4) @(negedge clk);
    chk("R5 break held", {tx_valid, tx_brk, irq_idok}, 3'b110);
    tx_ready = 1'b1;
    repeat (5) @(negedge clk);
    chk("R5 item count", tx_n - st, 3);
    chk("R5 break item", tx_log[8'(st)][8], 1);
    chk("R5 sync item", tx_log[8'(st + 1)], 9'h055);
    chk("R5 pid item", tx_log[8'(st + 2)], {1'b0, pid_of(6'h2A)});
    rd(4'd3, v); chk("R5 idok and id", {irq_idok, v[7:0]}, {1'b1, pid_of(6'h2A)});

    // R11 bit error while sending
    wr(4'd4, 8'h0F); tx_ready = 1'b0;
    wr(4'd1, 8'h01);
    @(negedge clk); bit_err = 1'b1; @(negedge clk); bit_err = 1'b0;
    tx_ready = 1'b1; @(negedge clk);
    rd(4'd4, v); chk("R11 bit error", {tx_valid, v[12:8], v[3]}, {1'b0, 5'b01000, 1'b1});

    // R10 selective clearing
    wr(4'd4, 8'h0F); wr(4'd0, 8'h00);
    hdr(p); wr(4'd2, 8'd1); wr(4'd1, 8'h02);
    rxb(8'h11, 1'b0); rxb(~csum_step(8'h00, 8'h11), 1'b0);
    chk("R10 both set", {irq_idok, irq_rxok}, 2'b11);
    repeat (5) @(negedge clk);
    chk("R10 sticky", {irq_idok, irq_rxok}, 2'b11);
    wr(4'd4, 8'h02);
    chk("R10 clear one", {irq_idok, irq_rxok}, 2'b10);

    // R12 clamp
    wr(4'd2, 8'd0);  rd(4'd2, v); chk("R12 clamp low", v, 1);
    wr(4'd2, 8'd12); rd(4'd2, v); chk("R12 clamp high", v, 8);
    wr(4'd2, 8'd5);  rd(4'd2, v); chk("R12 in range", v, 5);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule